// File: doc/BRIEF.md
# 64-bit Global Timer with Write Acknowledge

This block is a memory-mapped timer. It holds a 64-bit counter that free-runs while enabled. There is one 64-bit compare register and an interrupt line. Software reaches every register through a single-cycle 32-bit write/read port. The counter and the compare value each appear as a low word and a high word.

Writes to the counter, compare, step and control registers do not act at once. Each one travels through a fixed pipeline of `WR_LAT` cycles before it updates its target. When it lands, it sets a sticky acknowledge bit that software polls and then clears by writing a one.

A compare match raises a sticky interrupt flag. The flag reaches the `irq` pin only when it is enabled. When the re-arm mode is on, each match adds the programmed step to the compare value, which gives a periodic interrupt.

Register map (byte offsets, 32-bit words):

| Offset | Register |
|---|---|
| 0x00 | counter low |
| 0x04 | counter high |
| 0x08 | counter acknowledge |
| 0x0C | compare low |
| 0x10 | compare high |
| 0x14 | step |
| 0x18 | control |
| 0x1C | general acknowledge |
| 0x20 | interrupt flag |
| 0x24 | interrupt enable |

Top module: `gtimer64`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The counter steps by one each cycle while control bit 0 (run) is 1. It holds its value while that bit is 0.
- R3: A write to counter low (0x00) or counter high (0x04) changes the counter exactly `WR_LAT` cycles after the write cycle. It replaces only the addressed word.
- R4: When a counter write lands, it sets bit 0 (low word) or bit 1 (high word) of the counter acknowledge register (0x08). Before that cycle the bit stays clear.
- R5: When a write lands, it sets one bit of the general acknowledge register (0x1C): bit 0 for compare low, bit 1 for compare high, bit 2 for step, bit 3 for control.
- R6: Writing a 1 to a bit of either acknowledge register clears only that bit. If a write lands in the same cycle as a clear of its own bit, the bit stays set.
- R7: Writes to 0x08, 0x1C, 0x20 and 0x24 act on the next edge and set no acknowledge bit. Writes to unaligned or unmapped addresses change nothing, and those addresses read as 0.
- R8: A compare low write lands in a holding register only. The compare value (read at 0x0C/0x10) changes only when the compare high write lands, and then both words load together.
- R9: While run and control bit 1 (compare enable) are both 1, a counter equal to the compare value sets bit 0 of the interrupt flag (0x20). The flag stays set until software writes 1 to that bit.
- R10: `irq` is high exactly when interrupt flag bit 0 and interrupt enable (0x24) bit 0 are both 1.
- R11: With control bit 2 (re-arm) set, each match adds the zero-extended step (0x14) to the compare value. Without it, the compare value stays unchanged after a match.
- R12: The high counter word is returned live, with no snapshot. A high read followed by a low read in the next cycle can tear at the low-word wrap. A high, low, high sequence that is retried until both high reads agree yields a consistent value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW | Byte address for read and write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is an acknowledge clear that arrives on the same edge as the delayed write it acknowledges. The bench reaches it by issuing the write and then waiting exactly `WR_LAT - 1` idle cycles before writing the clear.

The torn 64-bit read at the low-word wrap needs the counter parked a few counts below the wrap before it is started. The bench then pairs each low read with the high word read one cycle earlier, and expects exactly one torn pair.

Re-arm is checked by reading the counter and the compare value in the same cycle at two different times. The expected compare value is computed from the counter.

// File: rtl/gtimer64_pkg.sv
package gtimer64_pkg;
    localparam int IDX_W = 4;

    // word index = byte address / 4
    localparam logic [IDX_W-1:0] RI_CNT_LO   = 4'd0;
    localparam logic [IDX_W-1:0] RI_CNT_HI   = 4'd1;
    localparam logic [IDX_W-1:0] RI_CNT_ACK  = 4'd2;
    localparam logic [IDX_W-1:0] RI_CMP_LO   = 4'd3;
    localparam logic [IDX_W-1:0] RI_CMP_HI   = 4'd4;
    localparam logic [IDX_W-1:0] RI_STEP     = 4'd5;
    localparam logic [IDX_W-1:0] RI_CTRL     = 4'd6;
    localparam logic [IDX_W-1:0] RI_GEN_ACK  = 4'd7;
    localparam logic [IDX_W-1:0] RI_IRQ_FLAG = 4'd8;
    localparam logic [IDX_W-1:0] RI_IRQ_EN   = 4'd9;

    localparam int CTL_RUN   = 0;
    localparam int CTL_CMPEN = 1;
    localparam int CTL_REARM = 2;
    localparam int CTL_W     = 3;

    localparam int GA_CMP_LO = 0;
    localparam int GA_CMP_HI = 1;
    localparam int GA_STEP   = 2;
    localparam int GA_CTRL   = 3;
    localparam int GA_W      = 4;

    function automatic logic is_slow(input logic [IDX_W-1:0] idx);
        return (idx == RI_CNT_LO) || (idx == RI_CNT_HI) || (idx == RI_CMP_LO) ||
               (idx == RI_CMP_HI) || (idx == RI_STEP)   || (idx == RI_CTRL);
    endfunction
endpackage

// File: rtl/gtimer64_wpipe.sv
module gtimer64_wpipe #(
    parameter int LAT   = 3,
    parameter int IDX_W = 4,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [DW-1:0]    in_data,
    output logic             out_vld,
    output logic [IDX_W-1:0] out_idx,
    output logic [DW-1:0]    out_data
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    data;
    } slot_t;

    slot_t [LAT-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = '{vld: in_vld, idx: in_idx, data: in_data};
        for (int i = 1; i < LAT; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_vld  = pipe_q[LAT-1].vld;
    assign out_idx  = pipe_q[LAT-1].idx;
    assign out_data = pipe_q[LAT-1].data;
endmodule

// File: rtl/gtimer64_core.sv
module gtimer64_core #(
    parameter int HW = 32,
    parameter int SW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            cmp_en,
    input  logic            rearm,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic [HW-1:0]   ld_word,
    input  logic            cmp_ld,
    input  logic [2*HW-1:0] cmp_val,
    input  logic [SW-1:0]   step,
    output logic [2*HW-1:0] cnt,
    output logic [2*HW-1:0] cmp,
    output logic            match
);
    localparam int CW = 2 * HW;
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmp;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        match = run & cmp_en & (st_q.cnt == st_q.cmp);
        if (run)   st_d.cnt = st_q.cnt + ONE;
        if (ld_lo) st_d.cnt = {st_q.cnt[CW-1:HW], ld_word};
        if (ld_hi) st_d.cnt = {ld_word, st_q.cnt[HW-1:0]};
        if (match && rearm) st_d.cmp = st_q.cmp + {{(CW-SW){1'b0}}, step};
        if (cmp_ld) st_d.cmp = cmp_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign cmp = st_q.cmp;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_lo && !ld_hi) |=> $stable(st_q.cnt)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_lo && !ld_hi) |=> (st_q.cnt == $past(st_q.cnt) + ONE)); // R2
    AST_CMP_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (match && rearm && !cmp_ld) |=> (st_q.cmp == $past(st_q.cmp) + {{(CW-SW){1'b0}}, $past(step)})); // R11
    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!(match && rearm) && !cmp_ld) |=> $stable(st_q.cmp)); // R8
endmodule

// File: rtl/gtimer64.sv
module gtimer64 #(
    parameter int WR_LAT = 3,
    parameter int AW     = 6,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    import gtimer64_pkg::*;

    localparam int CW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0]    cmp_lo_hold;
        logic [DW-1:0]    step;
        logic [CTL_W-1:0] ctrl;
        logic [1:0]       cnt_ack;
        logic [GA_W-1:0]  gen_ack;
        logic             irq_flag;
        logic             irq_en;
    } regs_t;

    regs_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic             addr_ok, wr_hit, slow_wr;
    logic             c_vld;
    logic [IDX_W-1:0] c_idx;
    logic [DW-1:0]    c_data;
    logic             ld_lo, ld_hi, cmp_ld, match;
    logic [CW-1:0]    cnt, cmp;

    assign idx     = bus_addr[IDX_W+1:2];
    assign addr_ok = (bus_addr[1:0] == 2'b00) && ((bus_addr >> (IDX_W + 2)) == '0);
    assign wr_hit  = bus_we && addr_ok;
    assign slow_wr = wr_hit && is_slow(idx);

    gtimer64_wpipe #(.LAT(WR_LAT), .IDX_W(IDX_W), .DW(DW)) u_wpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (slow_wr),
        .in_idx   (idx),
        .in_data  (bus_wdata),
        .out_vld  (c_vld),
        .out_idx  (c_idx),
        .out_data (c_data)
    );

    assign ld_lo  = c_vld && (c_idx == RI_CNT_LO);
    assign ld_hi  = c_vld && (c_idx == RI_CNT_HI);
    assign cmp_ld = c_vld && (c_idx == RI_CMP_HI);

    gtimer64_core #(.HW(DW), .SW(DW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.ctrl[CTL_RUN]),
        .cmp_en  (st_q.ctrl[CTL_CMPEN]),
        .rearm   (st_q.ctrl[CTL_REARM]),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_word (c_data),
        .cmp_ld  (cmp_ld),
        .cmp_val ({c_data, st_q.cmp_lo_hold}),
        .step    (st_q.step),
        .cnt     (cnt),
        .cmp     (cmp),
        .match   (match)
    );

    always_comb begin
        st_d = st_q;
        // immediate registers
        if (wr_hit) begin
            case (idx)
                RI_CNT_ACK:  st_d.cnt_ack = st_q.cnt_ack & ~bus_wdata[1:0];
                RI_GEN_ACK:  st_d.gen_ack = st_q.gen_ack & ~bus_wdata[GA_W-1:0];
                RI_IRQ_FLAG: if (bus_wdata[0]) st_d.irq_flag = 1'b0;
                RI_IRQ_EN:   st_d.irq_en = bus_wdata[0];
                default: ;
            endcase
        end
        // delayed writes land after the clears, so a set wins
        if (c_vld) begin
            case (c_idx)
                RI_CNT_LO: st_d.cnt_ack[0] = 1'b1;
                RI_CNT_HI: st_d.cnt_ack[1] = 1'b1;
                RI_CMP_LO: begin
                    st_d.cmp_lo_hold        = c_data;
                    st_d.gen_ack[GA_CMP_LO] = 1'b1;
                end
                RI_CMP_HI: st_d.gen_ack[GA_CMP_HI] = 1'b1;
                RI_STEP: begin
                    st_d.step             = c_data;
                    st_d.gen_ack[GA_STEP] = 1'b1;
                end
                RI_CTRL: begin
                    st_d.ctrl             = c_data[CTL_W-1:0];
                    st_d.gen_ack[GA_CTRL] = 1'b1;
                end
                default: ;
            endcase
        end
        if (match) st_d.irq_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            case (idx)
                RI_CNT_LO:   bus_rdata = cnt[DW-1:0];
                RI_CNT_HI:   bus_rdata = cnt[CW-1:DW];
                RI_CNT_ACK:  bus_rdata = DW'(st_q.cnt_ack);
                RI_CMP_LO:   bus_rdata = cmp[DW-1:0];
                RI_CMP_HI:   bus_rdata = cmp[CW-1:DW];
                RI_STEP:     bus_rdata = st_q.step;
                RI_CTRL:     bus_rdata = DW'(st_q.ctrl);
                RI_GEN_ACK:  bus_rdata = DW'(st_q.gen_ack);
                RI_IRQ_FLAG: bus_rdata = DW'(st_q.irq_flag);
                RI_IRQ_EN:   bus_rdata = DW'(st_q.irq_en);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irq = st_q.irq_flag & st_q.irq_en;

    AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt_ack[0] && !(wr_hit && idx == RI_CNT_ACK && bus_wdata[0])) |=> st_q.cnt_ack[0]); // R6
    AST_CTRL_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_vld && c_idx == RI_CTRL) |=> st_q.gen_ack[GA_CTRL]); // R5
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> st_q.irq_flag); // R9
    AST_FAST_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx == RI_IRQ_EN && !c_vld) |=> ($stable(st_q.cnt_ack) && $stable(st_q.gen_ack))); // R7
endmodule

// File: tb/gtimer64_test.sv
module gtimer64_test;
    localparam int WLAT = 3;

    localparam logic [5:0] A_CLO = 6'h00, A_CHI = 6'h04, A_CACK = 6'h08, A_MLO = 6'h0C,
                           A_MHI = 6'h10, A_STEP = 6'h14, A_CTL = 6'h18, A_GACK = 6'h1C,
                           A_FLAG = 6'h20, A_EN = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gtimer64 #(.WR_LAT(WLAT)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic [31:0] d;
        logic [1:0]  ecnt;
        logic [3:0]  egen;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{6'h00, 32'h11, 2'b01, 4'b0000},
        '{6'h04, 32'h22, 2'b10, 4'b0000},
        '{6'h0C, 32'h05, 2'b00, 4'b0001},
        '{6'h10, 32'h00, 2'b00, 4'b0010},
        '{6'h14, 32'h07, 2'b00, 4'b0100},
        '{6'h18, 32'h00, 2'b00, 4'b1000},
        '{6'h24, 32'h00, 2'b00, 4'b0000},
        '{6'h20, 32'h01, 2'b00, 4'b0000}
    };

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // caller sits at a negedge; returns at the negedge after the capturing edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] rearm_exp(input logic [31:0] x);
        if (x <= 32'd20) return 32'd20;
        return 32'd20 + 32'd10 * ((x - 32'd20 + 32'd9) / 32'd10);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all R): actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2, hp, lo;
        int torn;
        waitc(3);
        rst_n = 1'b1;
        waitc(1);

        // R1: reset values
        for (int i = 0; i < 10; i++) begin
            rd(6'(i * 4), v);
            chk("R1", "reset register", 64'(v), 64'h0);
        end
        chk("R1", "reset irq", 64'(irq), 64'h0);

        // R4 R5 R7: acknowledge decode table
        foreach (VEC[i]) begin
            wr(A_CACK, 32'h3);
            wr(A_GACK, 32'hF);
            wr(VEC[i].a, VEC[i].d);
            waitc(WLAT);
            rd(A_CACK, v);
            chk("R4", "counter ack after write", 64'(v), 64'(VEC[i].ecnt));
            rd(A_GACK, v);
            chk("R5", "general ack after write", 64'(v), 64'(VEC[i].egen));
        end
        rd(6'h28, v);
        chk("R7", "unmapped read", 64'(v), 64'h0);

        // R3: exact latency of a counter write (counter stopped, value 0x22_00000011)
        wr(A_CLO, 32'hFFFF_FFF0);
        waitc(WLAT - 1);
        rd(A_CLO, v);
        chk("R3", "low word before latency", 64'(v), 64'h11);
        rd(A_CACK, v);
        chk("R4", "ack before latency", 64'(v), 64'h0);
        waitc(1);
        rd(A_CLO, v);
        chk("R3", "low word at latency", 64'(v), 64'hFFFF_FFF0);
        rd(A_CHI, v);
        chk("R3", "high word untouched", 64'(v), 64'h22);
        rd(A_CACK, v);
        chk("R4", "ack at latency", 64'(v), 64'h1);

        // R6: write-one-to-clear and set-wins collision
        wr(A_CHI, 32'h33);
        waitc(WLAT);
        rd(A_CACK, v);
        chk("R4", "both ack bits", 64'(v), 64'h3);
        wr(A_CACK, 32'h2);
        rd(A_CACK, v);
        chk("R6", "clear high bit only", 64'(v), 64'h1);
        wr(A_CACK, 32'h1);
        rd(A_CACK, v);
        chk("R6", "clear low bit", 64'(v), 64'h0);
        wr(A_CLO, 32'h44);
        waitc(WLAT - 1);
        wr(A_CACK, 32'h1);
        rd(A_CACK, v);
        chk("R6", "set wins over clear", 64'(v), 64'h1);
        rd(A_CLO, v);
        chk("R3", "low word after collision", 64'(v), 64'h44);

        // R2: run and hold
        wr(A_CLO, 32'h0);
        wr(A_CHI, 32'h0);
        wr(A_CTL, 32'h1);
        waitc(WLAT + 2);
        rd(A_CLO, v);
        waitc(10);
        rd(A_CLO, v2);
        chk("R2", "ten cycles counted", 64'(v2 - v), 64'd10);
        wr(A_CTL, 32'h0);
        waitc(WLAT + 1);
        rd(A_CLO, v);
        waitc(5);
        rd(A_CLO, v2);
        chk("R2", "stopped counter holds", 64'(v2), 64'(v));

        // R8: compare low is staged until compare high lands
        wr(A_MLO, 32'h100);
        waitc(WLAT);
        rd(A_MLO, v);
        chk("R8", "compare low still old", 64'(v), 64'h5);
        wr(A_MHI, 32'h0);
        waitc(WLAT);
        rd(A_MLO, v);
        chk("R8", "compare low loaded", 64'(v), 64'h100);
        rd(A_MHI, v);
        chk("R8", "compare high loaded", 64'(v), 64'h0);

        // R9 R10 R11: single match without re-arm
        wr(A_CLO, 32'hF0);
        wr(A_CTL, 32'h3);
        waitc(WLAT);
        rd(A_FLAG, v);
        chk("R9", "no flag before match", 64'(v), 64'h0);
        waitc(40);
        rd(A_FLAG, v);
        chk("R9", "flag after match", 64'(v), 64'h1);
        chk("R10", "irq masked", 64'(irq), 64'h0);
        rd(A_MLO, v);
        chk("R11", "compare kept without re-arm", 64'(v), 64'h100);
        wr(A_EN, 32'h1);
        chk("R10", "irq enabled", 64'(irq), 64'h1);
        wr(A_FLAG, 32'h1);
        rd(A_FLAG, v);
        chk("R9", "flag cleared", 64'(v), 64'h0);
        chk("R10", "irq low after clear", 64'(irq), 64'h0);

        // R11: periodic re-arm, compare 20, step 10
        wr(A_CTL, 32'h0);
        wr(A_EN, 32'h0);
        wr(A_CLO, 32'h0);
        wr(A_CHI, 32'h0);
        wr(A_MLO, 32'd20);
        wr(A_MHI, 32'h0);
        wr(A_STEP, 32'd10);
        waitc(WLAT);
        wr(A_FLAG, 32'h1);
        wr(A_CTL, 32'h7);
        waitc(WLAT + 37);
        rd(A_CLO, v);
        rd(A_MLO, v2);
        chk("R11", "re-armed compare (first)", 64'(v2), 64'(rearm_exp(v)));
        waitc(13);
        rd(A_CLO, v);
        rd(A_MLO, v2);
        chk("R11", "re-armed compare (second)", 64'(v2), 64'(rearm_exp(v)));
        rd(A_FLAG, v);
        chk("R9", "flag from periodic match", 64'(v), 64'h1);

        // R12: torn read across the low-word wrap
        wr(A_CTL, 32'h0);
        wr(A_CHI, 32'h0);
        wr(A_CLO, 32'hFFFF_FFF0);
        wr(A_CTL, 32'h1);
        waitc(WLAT);
        torn = 0;
        rd(A_CHI, hp);
        for (int i = 0; i < 40; i++) begin
            waitc(1);
            rd(A_CLO, lo);
            if (hp == 32'h0 && lo < 32'h10) torn++;
            rd(A_CHI, hp);
        end
        chk("R12", "torn pairs at wrap", 64'(torn), 64'd1);
        do begin
            waitc(1);
            rd(A_CHI, hp);
            waitc(1);
            rd(A_CLO, lo);
            waitc(1);
            rd(A_CHI, v);
        end while (hp != v);
        chk("R12", "consistent high word", 64'(hp), 64'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule